// File: doc/BRIEF.md
# Split-Access Asynchronous Memory Read Controller

This block serves 32-bit reads from an external asynchronous memory or peripheral that has a 16-bit data path. A request from the internal side carries a word address. The controller runs two 16-bit accesses one after the other. The lower half is read at the even halfword address and the upper half at the odd halfword address. A programmable idle gap separates the two accesses. The block drives chip select, address valid, output enable, byte enables, the halfword address and a bus-direction line. It captures the external data and returns the assembled 32-bit word with a single-cycle done pulse.

Timing comes from fields that are sampled when a request is accepted:
- a wait-state count, which sets the minimum access length;
- output-enable setup and hold;
- address-valid hold;
- the turnaround gap.

When handshake mode is set, each access also waits for an asynchronous ready input, after a two-flop synchronizer, to be seen high. Handshake mode does not change the address-valid and output-enable start timing. It removes the output-enable hold, so the strobes drop together when the access ends. If a non-zero hold is programmed together with handshake mode, a registered configuration-error flag is raised.

The controller is a four-state machine:
- ST_IDLE waits for a request and is the only state that accepts one.
- ST_ACCESS drives one 16-bit access.
- ST_TURN is the idle gap between the two halves.
- ST_DONE issues the result pulse.

Its transitions are:
- tr_accept: ST_IDLE to ST_ACCESS, on a request.
- tr_half_end: ST_ACCESS to ST_TURN, when the lower access completes.
- tr_gap_end: ST_TURN to ST_ACCESS, when the gap count is exhausted.
- tr_word_end: ST_ACCESS to ST_DONE, when the upper access completes.
- tr_report: ST_DONE to ST_IDLE, unconditionally.

Top module: `amem_rd_ctrl`

## Requirements
- R1: A request is served as two accesses. The first drives ext_addr = {req_addr, 1'b0} and its data becomes rd_data[15:0]. The second drives ext_addr = {req_addr, 1'b1} and its data becomes rd_data[31:16]. The address stays constant for as long as ext_cs_n is low.
- R2: Outside handshake mode, ext_cs_n is low for exactly cfg_wait+1 consecutive cycles per access, whatever the level of ext_rdy.
- R3: ext_adv_n is low for the first min(cfg_adv_hold+1, access length) cycles of each access, and never while ext_cs_n is high.
- R4: ext_oe_n goes low in access cycle cfg_oe_setup, counting from 0. It stays low until hold cycles before the access ends, where hold is cfg_oe_hold outside handshake mode and 0 inside it. If setup+hold reaches the access length, it stays high.
- R5: ext_dir is 0 (input) in exactly the cycles in which ext_oe_n is low and 1 otherwise. ext_be_n is 2'b00 while ext_cs_n is low and 2'b11 otherwise.
- R6: In handshake mode an access completes in the first cycle at or after access cycle cfg_wait in which the two-flop-synchronized ext_rdy is 1. If ready rises after the negedge of access cycle K-1, the access lasts max(cfg_wait, K+1)+1 cycles.
- R7: cfg_err is 1 one cycle after cfg_hs_en=1 is applied together with a non-zero cfg_oe_hold, and 0 otherwise. In that case the hold is treated as zero and output enable is released together with chip select.
- R8: Between the two accesses, ext_cs_n, ext_adv_n and ext_oe_n stay high for exactly cfg_turn+1 cycles.
- R9: rd_done is a one-cycle pulse in the cycle right after the upper access ends, and rd_data then holds the assembled word. A request presented while req_rdy is 0 is ignored and starts no further access.
- R10: During and after reset the bus is idle: ext_cs_n, ext_adv_n and ext_oe_n are 1, ext_dir is 1, ext_be_n is 2'b11, rd_done is 0 and req_rdy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Read request, taken when req_rdy is 1 |
| req_addr | input | AW | 32-bit word address |
| req_rdy | output | 1 | Controller idle and able to take a request |
| cfg_wait | input | WSW | Minimum access length minus one |
| cfg_oe_setup | input | TW | Cycles from chip select to output enable |
| cfg_oe_hold | input | TW | Cycles output enable is released before the access ends |
| cfg_adv_hold | input | TW | Address-valid pulse width minus one |
| cfg_turn | input | TW | Gap between halves minus one |
| cfg_hs_en | input | 1 | Enable ready handshake |
| cfg_err | output | 1 | Handshake with non-zero hold programmed |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_adv_n | output | 1 | Address valid, active low |
| ext_oe_n | output | 1 | Output enable, active low |
| ext_be_n | output | 2 | Byte enables, active low |
| ext_addr | output | AW+1 | Halfword address |
| ext_dir | output | 1 | Bus direction, 0 = input |
| ext_din | input | DW | External read data |
| ext_rdy | input | 1 | Asynchronous device ready |
| rd_data | output | 2*DW | Assembled read word |
| rd_done | output | 1 | One-cycle result strobe |

## Verification
Two events can fall into the same cycle in handshake mode: the wait-state counter reaching zero and the synchronized ready turning high. The bench provokes this by raising ready so that its synchronized copy arrives exactly in access cycle cfg_wait. Other cases make ready arrive clearly before or after that cycle. It judges each case by the chip-select length, which must be max(cfg_wait, K+1)+1 with no extra or missing cycle. It also requires output enable to release in the same cycle as chip select.

// File: rtl/amem_pkg.sv
package amem_pkg;

    // Controller phases for one 32-bit read.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_TURN   = 2'd2,
        ST_DONE   = 2'd3
    } amem_state_e;

    // Depth of the ready synchronizer.
    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/amem_rdy_sync.sv
module amem_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    generate
        if (STAGES < 2) begin : g_single
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= 1'b0;
                else        q <= async_in;
            end
            assign sync_out = q;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], async_in};
            end
            assign sync_out = sh[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/amem_down_cnt.sv
module amem_down_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] value,
    output logic         zero
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          value <= '0;
        else if (load)       value <= load_val;
        else if (dec && !zero) value <= value - 1'b1;
    end

    assign zero = (value == '0);

endmodule

// File: rtl/amem_sat_cnt.sv
module amem_sat_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   value <= '0;
        else if (clr)                 value <= '0;
        else if (inc && value != '1)  value <= value + 1'b1;
    end

endmodule

// File: rtl/amem_rd_ctrl.sv
module amem_rd_ctrl
    import amem_pkg::*;
#(
    parameter int AW  = 23,
    parameter int DW  = 16,
    parameter int WSW = 6,
    parameter int TW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_vld,
    input  logic [AW-1:0]   req_addr,
    output logic            req_rdy,
    input  logic [WSW-1:0]  cfg_wait,
    input  logic [TW-1:0]   cfg_oe_setup,
    input  logic [TW-1:0]   cfg_oe_hold,
    input  logic [TW-1:0]   cfg_adv_hold,
    input  logic [TW-1:0]   cfg_turn,
    input  logic            cfg_hs_en,
    output logic            cfg_err,
    output logic            ext_cs_n,
    output logic            ext_adv_n,
    output logic            ext_oe_n,
    output logic [1:0]      ext_be_n,
    output logic [AW:0]     ext_addr,
    output logic            ext_dir,
    input  logic [DW-1:0]   ext_din,
    input  logic            ext_rdy,
    output logic [2*DW-1:0] rd_data,
    output logic            rd_done
);

    localparam int MW = (WSW > TW) ? WSW : TW;
    localparam int EW = MW + 1;

    function automatic logic [EW-1:0] ext_t(input logic [TW-1:0] v);
        return {{(EW-TW){1'b0}}, v};
    endfunction

    function automatic logic [EW-1:0] ext_w(input logic [WSW-1:0] v);
        return {{(EW-WSW){1'b0}}, v};
    endfunction

    amem_state_e st_q, st_d;

    // Per-request copy of the timing fields.
    logic [AW-1:0]  addr_q;
    logic [WSW-1:0] wait_q;
    logic [TW-1:0]  setup_q, hold_q, adv_q, turn_q;
    logic           hs_q;
    logic           half_q;
    logic [DW-1:0]  lo_q, hi_q;
    logic           err_q;

    logic           rdy_s;
    logic [WSW-1:0] rem;
    logic           rem_zero;
    logic [EW-1:0]  el;
    logic [TW-1:0]  gap;
    logic           gap_zero;

    logic tr_accept, tr_half_end, tr_gap_end, tr_word_end;
    logic acc_done, acc_load;
    logic adv_on, oe_on;

    // Transition conditions.
    assign tr_accept   = (st_q == ST_IDLE) && req_vld;
    assign acc_done    = (st_q == ST_ACCESS) && rem_zero && (!hs_q || rdy_s);
    assign tr_half_end = acc_done && !half_q;
    assign tr_word_end = acc_done && half_q;
    assign tr_gap_end  = (st_q == ST_TURN) && gap_zero;
    assign acc_load    = tr_accept || tr_gap_end;

    amem_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_rdy),
        .sync_out (rdy_s)
    );

    // Remaining wait states of the current access.
    amem_down_cnt #(.W(WSW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_load),
        .load_val (tr_accept ? cfg_wait : wait_q),
        .dec      (st_q == ST_ACCESS),
        .value    (rem),
        .zero     (rem_zero)
    );

    // Cycles elapsed since chip select went active.
    amem_sat_cnt #(.W(EW)) u_elapsed (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_load),
        .inc   (st_q == ST_ACCESS),
        .value (el)
    );

    // Idle gap between the halves.
    amem_down_cnt #(.W(TW)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tr_half_end),
        .load_val (turn_q),
        .dec      (st_q == ST_TURN),
        .value    (gap),
        .zero     (gap_zero)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (tr_accept) st_d = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (tr_half_end)      st_d = ST_TURN;
                else if (tr_word_end) st_d = ST_DONE;
            end
            ST_TURN: begin
                if (tr_gap_end) st_d = ST_ACCESS;
            end
            ST_DONE: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Request capture, half select and data capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wait_q  <= '0;
            setup_q <= '0;
            hold_q  <= '0;
            adv_q   <= '0;
            turn_q  <= '0;
            hs_q    <= 1'b0;
            half_q  <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            if (tr_accept) begin
                addr_q  <= req_addr;
                wait_q  <= cfg_wait;
                setup_q <= cfg_oe_setup;
                hold_q  <= cfg_hs_en ? '0 : cfg_oe_hold;
                adv_q   <= cfg_adv_hold;
                turn_q  <= cfg_turn;
                hs_q    <= cfg_hs_en;
                half_q  <= 1'b0;
            end
            if (tr_half_end) begin
                lo_q   <= ext_din;
                half_q <= 1'b1;
            end
            if (tr_word_end) begin
                hi_q <= ext_din;
            end
        end
    end

    // Configuration check on the live fields.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= cfg_hs_en && (cfg_oe_hold != '0);
    end

    assign cfg_err = err_q;
    assign rd_data = {hi_q, lo_q};

    assign adv_on = (el <= ext_t(adv_q));
    assign oe_on  = (el >= ext_t(setup_q)) && (ext_w(rem) >= ext_t(hold_q));

    // Outputs decoded from the state.
    always_comb begin
        req_rdy   = 1'b0;
        rd_done   = 1'b0;
        ext_cs_n  = 1'b1;
        ext_adv_n = 1'b1;
        ext_oe_n  = 1'b1;
        ext_be_n  = 2'b11;
        ext_addr  = '0;
        ext_dir   = 1'b1;
        unique case (st_q)
            ST_IDLE: begin
                req_rdy = 1'b1;
            end
            ST_ACCESS: begin
                ext_cs_n  = 1'b0;
                ext_be_n  = 2'b00;
                ext_addr  = {addr_q, half_q};
                ext_adv_n = !adv_on;
                ext_oe_n  = !oe_on;
                ext_dir   = !oe_on;
            end
            ST_TURN: begin
                ext_cs_n = 1'b1;
            end
            ST_DONE: begin
                rd_done = 1'b1;
            end
            default: begin
                req_rdy = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/amem_rd_chk.sv
module amem_rd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_cs_n,
    input logic       ext_adv_n,
    input logic       ext_oe_n,
    input logic [1:0] ext_be_n,
    input logic       req_rdy,
    input logic       rd_done
);

    p_adv_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_adv_n |-> !ext_cs_n);

    p_cs_start_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_cs_n) |-> !ext_adv_n);

    p_oe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_oe_n |-> !ext_cs_n);

    p_be_follow_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_cs_n |-> (ext_be_n == 2'b11));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    p_done_after_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> ($past(!ext_cs_n) && !req_rdy));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_rdy |-> (ext_cs_n && ext_oe_n && ext_adv_n));

endmodule

bind amem_rd_ctrl amem_rd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_cs_n  (ext_cs_n),
    .ext_adv_n (ext_adv_n),
    .ext_oe_n  (ext_oe_n),
    .ext_be_n  (ext_be_n),
    .req_rdy   (req_rdy),
    .rd_done   (rd_done)
);

// File: tb/sim_amem_rd_ctrl.sv
`timescale 1ns/1ps
module sim_amem_rd_ctrl;

    localparam int AW  = 23;
    localparam int DW  = 16;
    localparam int WSW = 6;
    localparam int TW  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_vld = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic            req_rdy;
    logic [WSW-1:0]  cfg_wait = '0;
    logic [TW-1:0]   cfg_oe_setup = '0, cfg_oe_hold = '0, cfg_adv_hold = '0, cfg_turn = '0;
    logic            cfg_hs_en = 1'b0;
    logic            cfg_err;
    logic            ext_cs_n, ext_adv_n, ext_oe_n, ext_dir;
    logic [1:0]      ext_be_n;
    logic [AW:0]     ext_addr;
    logic [DW-1:0]   ext_din;
    logic            ext_rdy = 1'b0;
    logic [2*DW-1:0] rd_data;
    logic            rd_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    amem_rd_ctrl #(.AW(AW), .DW(DW), .WSW(WSW), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .req_rdy(req_rdy), .cfg_wait(cfg_wait), .cfg_oe_setup(cfg_oe_setup),
        .cfg_oe_hold(cfg_oe_hold), .cfg_adv_hold(cfg_adv_hold), .cfg_turn(cfg_turn),
        .cfg_hs_en(cfg_hs_en), .cfg_err(cfg_err), .ext_cs_n(ext_cs_n),
        .ext_adv_n(ext_adv_n), .ext_oe_n(ext_oe_n), .ext_be_n(ext_be_n),
        .ext_addr(ext_addr), .ext_dir(ext_dir), .ext_din(ext_din),
        .ext_rdy(ext_rdy), .rd_data(rd_data), .rd_done(rd_done)
    );

    // Memory model: the data is a function of the halfword address.
    function automatic logic [DW-1:0] mem_f(input logic [AW:0] a);
        return a[15:0] ^ {a[AW:AW-7], a[7:0]} ^ 16'h5A3C;
    endfunction

    assign ext_din = (!ext_cs_n) ? mem_f(ext_addr) : 16'hDEAD;

    // Monitor state.
    bit hs_b = 1'b0;
    int k_b = 1;
    int hcount = 0, idx = 0, gap_len = 0;
    int cs_len[2], adv_len[2], oe_len[2], oe_first[2];
    logic [AW:0] addr_seen[2];
    int dir_bad = 0, be_bad = 0, addr_bad = 0, idle_bad = 0;
    int done_cnt = 0, done_ok = 0;
    bit prev_cs = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ext_cs_n) begin
                if (!prev_cs) begin
                    idx = 0;
                    if (hcount < 2) begin
                        cs_len[hcount] = 0; adv_len[hcount] = 0;
                        oe_len[hcount] = 0; oe_first[hcount] = -1;
                        addr_seen[hcount] = ext_addr;
                    end
                end
                if (hcount < 2) begin
                    cs_len[hcount]++;
                    if (!ext_adv_n) adv_len[hcount]++;
                    if (!ext_oe_n) begin
                        if (oe_len[hcount] == 0) oe_first[hcount] = idx;
                        oe_len[hcount]++;
                    end
                    if (ext_addr != addr_seen[hcount]) addr_bad++;
                end
                if (ext_be_n != 2'b00) be_bad++;
                if (hs_b && (idx + 1 == k_b)) ext_rdy = 1'b1;
                idx++;
            end else begin
                ext_rdy = 1'b0;
                if (prev_cs) hcount++;
                if (hcount == 1) gap_len++;
                if (!ext_adv_n || !ext_oe_n || ext_be_n != 2'b11) idle_bad++;
            end
            if (ext_dir !== ext_oe_n) dir_bad++;
            if (rd_done) begin
                done_cnt++;
                if (prev_cs && hcount == 2) done_ok++;
            end
            prev_cs = !ext_cs_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_len(input int w, input bit hs, input int k);
        if (!hs) return w + 1;
        return ((w > k + 1) ? w : k + 1) + 1;
    endfunction

    function automatic int exp_oe(input int len, input int s, input int h, input bit hs);
        int he = hs ? 0 : h;
        return (len > s + he) ? len - s - he : 0;
    endfunction

    function automatic int exp_adv(input int len, input int a);
        return (a + 1 < len) ? a + 1 : len;
    endfunction

    task automatic run_txn(input logic [AW-1:0] a, input int w, input int s, input int hd,
                           input int av, input int t, input bit hs, input int k, input bit poke);
        int n;
        int len, eo, ea;
        logic [2*DW-1:0] ed;
        @(negedge clk); #1;
        cfg_wait = w[WSW-1:0]; cfg_oe_setup = s[TW-1:0]; cfg_oe_hold = hd[TW-1:0];
        cfg_adv_hold = av[TW-1:0]; cfg_turn = t[TW-1:0]; cfg_hs_en = hs;
        hs_b = hs; k_b = k;
        hcount = 0; gap_len = 0; dir_bad = 0; be_bad = 0; addr_bad = 0;
        idle_bad = 0; done_cnt = 0; done_ok = 0;
        @(negedge clk); @(negedge clk); #1;
        chk(cfg_err == (hs && hd != 0), "R7 cfg_err flag", cfg_err, hs && hd != 0);
        chk(req_rdy == 1'b1, "R10 idle before request", req_rdy, 1);
        req_addr = a; req_vld = 1'b1;
        @(negedge clk); #1;
        req_vld = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            #1;
            chk(req_rdy == 1'b0, "R9 busy during access", req_rdy, 0);
            req_addr = ~a; req_vld = 1'b1;
            @(negedge clk); #1;
            req_vld = 1'b0;
        end
        n = 0;
        while (done_cnt == 0 && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(n < 3000, "R9 completion timeout", n, 0);
        repeat (4) @(negedge clk);
        #1;
        len = exp_len(w, hs, k);
        eo  = exp_oe(len, s, hd, hs);
        ea  = exp_adv(len, av);
        ed  = {mem_f({a, 1'b1}), mem_f({a, 1'b0})};
        chk(hcount == 2, "R9 exactly two accesses", hcount, 2);
        chk(addr_seen[0] == {a, 1'b0}, "R1 lower half address", addr_seen[0], {a, 1'b0});
        chk(addr_seen[1] == {a, 1'b1}, "R1 upper half address", addr_seen[1], {a, 1'b1});
        chk(addr_bad == 0, "R1 address stable", addr_bad, 0);
        for (int h = 0; h < 2; h++) begin
            chk(cs_len[h] == len, hs ? "R6 handshake access length" : "R2 access length",
                cs_len[h], len);
            chk(adv_len[h] == ea, "R3 address valid width", adv_len[h], ea);
            chk(oe_len[h] == eo, hs ? "R7 oe length no hold" : "R4 oe length", oe_len[h], eo);
            if (eo > 0)
                chk(oe_first[h] == s, "R4 oe start cycle", oe_first[h], s);
        end
        chk(dir_bad == 0, "R5 direction follows oe", dir_bad, 0);
        chk(be_bad == 0, "R5 byte enables in access", be_bad, 0);
        chk(idle_bad == 0, "R8 strobes idle outside access", idle_bad, 0);
        chk(gap_len == t + 1, "R8 turnaround gap", gap_len, t + 1);
        chk(done_cnt == 1 && done_ok == 1, "R9 single done after access", done_cnt, 1);
        chk(rd_data == ed, "R1 R9 assembled data", rd_data, ed);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1;
        chk(ext_cs_n && ext_adv_n && ext_oe_n && ext_dir && ext_be_n == 2'b11,
            "R10 bus idle in reset", {ext_cs_n, ext_adv_n, ext_oe_n, ext_dir}, 4'hF);
        chk(!rd_done, "R10 no done in reset", rd_done, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_rdy && ext_cs_n && ext_oe_n, "R10 idle after reset", req_rdy, 1);

        // Directed corner cases.
        run_txn(23'h012345, 0, 0, 0, 0, 0, 1'b0, 1, 1'b0);  // shortest access
        run_txn(23'h2AAAAA, 4, 1, 1, 0, 0, 1'b0, 1, 1'b0);  // typical timing
        run_txn(23'h155555, 6, 2, 1, 1, 2, 1'b0, 1, 1'b0);
        run_txn(23'h00FF00, 2, 3, 0, 7, 3, 1'b0, 1, 1'b0);  // oe never active
        run_txn(23'h400001, 4, 1, 0, 1, 1, 1'b1, 3, 1'b0);  // ready meets counter expiry
        run_txn(23'h123456, 5, 1, 0, 0, 0, 1'b1, 2, 1'b0);  // ready early
        run_txn(23'h7FFFFF, 2, 1, 2, 0, 1, 1'b1, 8, 1'b0);  // ready late, hold overridden
        run_txn(23'h0A0A0A, 5, 1, 1, 1, 2, 1'b0, 1, 1'b1);  // request while busy

        // Random mix.
        for (int i = 0; i < 40; i++) begin
            bit hs;
            int w, k;
            hs = $urandom_range(0, 1);
            w  = hs ? $urandom_range(1, 9) : $urandom_range(0, 9);
            k  = $urandom_range(1, 10);
            run_txn($urandom_range(0, 32'h7FFFFF), w, $urandom_range(0, 3),
                    $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                    hs, k, 1'b0);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule